// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer Window

This block lets a host reach into packet buffers one byte at a time. Each buffer is 2048 bytes, and the host never addresses it directly. It loads a 16-bit pointer register and then reads or writes through a data port that has four byte lanes. The pointer carries an 11-bit byte offset and two control bits. One control bit picks which buffer is accessed: the buffer index at the head of the receive queue, or the buffer index held in the packet-number register. Both indices arrive as inputs. The other control bit makes every data-port access advance the offset by one.

The block turns each data-port access into a registered request on a simple synchronous buffer RAM. The RAM address is the buffer index joined to the byte offset. Read data comes back from the RAM and is returned to the host with a valid strobe. The block holds no buffer storage of its own.

The pointer can be read back at any time. Its two bytes can be written separately, and a pointer write may share a cycle with a data-port access.

Top module: `ptrwin_top`

## Requirements
- R1: After synchronous reset the pointer reads back as 0x0000 and dp_rvalid, ram_we and ram_re are low.
- R2: ptr_we[0] loads pointer bits 7:0 from ptr_wdata[7:0] and ptr_we[1] loads bits 15:8 from ptr_wdata[15:8]. A byte that is not enabled keeps its value.
- R3: ptr_rdata shows the stored pointer with bit 11 forced to 0, so the high byte reads as the stored value ANDed with 0xF7. It is updated on the clock edge that updates the pointer.
- R4: With pointer bit 15 set, an access targets buffer rx_head; with it clear, it targets buffer pkt_num. Both indices are sampled in the access cycle.
- R5: With pointer bit 14 clear, the access offset is pointer bits 10:0 plus dp_lane, modulo 2048, and the pointer does not change.
- R6: With pointer bit 14 set, the access offset is pointer bits 10:0 and dp_lane is ignored. After each read or write, bits 10:0 advance by one and wrap from 2047 to 0, while bits 15:11 keep their values.
- R7: A data write stores dp_wdata at the addressed byte. A data read returns the addressed byte on dp_rdata, with dp_rvalid high for one cycle, in the third cycle after the access cycle. The returned byte includes all earlier writes. A write never raises dp_rvalid.
- R8: When a pointer write and a data access fall in the same cycle, the pointer write is applied first. The access and any auto-increment then use the merged pointer value.
- R9: In the cycle after an access, ram_addr holds the buffer index in bits BUF_W+10:11 and the offset in bits 10:0. ram_we is high only for writes, ram_re only for reads, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 2 | Pointer byte write enables (bit 0 low byte, bit 1 high byte) |
| ptr_wdata | input | 16 | Pointer write data |
| ptr_rdata | output | 16 | Registered pointer readback, bit 11 masked |
| dp_valid | input | 1 | Data-port access strobe |
| dp_write | input | 1 | 1 = write, 0 = read |
| dp_lane | input | LANE_W | Byte lane of the data port (0 to LANES-1) |
| dp_wdata | input | DATA_W | Data-port write byte |
| dp_rvalid | output | 1 | Read data valid |
| dp_rdata | output | DATA_W | Read data byte |
| rx_head | input | BUF_W | Buffer index at the head of the receive queue |
| pkt_num | input | BUF_W | Buffer index from the packet-number register |
| ram_addr | output | BUF_W+OFS_W | Buffer RAM address {buffer, offset} |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_re | output | 1 | Buffer RAM read enable |
| ram_wdata | output | DATA_W | Buffer RAM write data |
| ram_rdata | input | DATA_W | Buffer RAM read data, one cycle after ram_re |

## Verification
A pointer write and a data-port access can land in the same cycle. The design must let the access see the freshly merged pointer, not the old one. The bench provokes this with full-word and single-byte pointer writes alongside reads and writes, both with auto-increment on and with it off. The cycle-accurate model in the bench merges the written bytes first and then derives the buffer, the offset and the stepped pointer. It judges the outcome on every clock from the RAM request, the pointer readback and the returned bytes.

// File: rtl/ptrwin_pkg.sv
package ptrwin_pkg;

  localparam int PTR_W     = 16;
  localparam int AUTO_BIT  = 14;
  localparam int RXSEL_BIT = 15;
  localparam int RSVD_BIT  = 11;

  localparam logic [PTR_W-1:0] READ_MASK = ~(PTR_W'(1) << RSVD_BIT);

  function automatic logic [PTR_W-1:0] merge_bytes(
      input logic [PTR_W-1:0] cur,
      input logic [1:0]       be,
      input logic [PTR_W-1:0] wd);
    logic [PTR_W-1:0] r;
    r = cur;
    if (be[0]) r[7:0]  = wd[7:0];
    if (be[1]) r[15:8] = wd[15:8];
    return r;
  endfunction

endpackage

// File: rtl/ptrwin_ptr_reg.sv
module ptrwin_ptr_reg
  import ptrwin_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       wr_be,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_eff,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_rd_q
);

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_eff = merge_bytes(ptr_q, wr_be, wr_data);
    ptr_nxt = ptr_eff;
    if (step && ptr_eff[AUTO_BIT])
      ptr_nxt[OFS_W-1:0] = ptr_eff[OFS_W-1:0] + OFS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      ptr_rd_q <= '0;
    end else begin
      ptr_q    <= ptr_nxt;
      ptr_rd_q <= ptr_nxt & READ_MASK;
    end
  end

  // R6: auto-increment advances the offset by one and keeps the control bits
  a_r6_auto_step: assert property (@(posedge clk) disable iff (rst)
    (step && wr_be == 2'b00 && ptr_q[AUTO_BIT]) |=>
      (ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + OFS_W'(1)) &&
      (ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W])));

  // R5: without auto-increment an access leaves the pointer alone
  a_r5_no_step: assert property (@(posedge clk) disable iff (rst)
    (wr_be == 2'b00 && !ptr_q[AUTO_BIT]) |=> $stable(ptr_q));

  // R2: a low-byte write keeps the high byte
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_be == 2'b01 && !step) |=>
      (ptr_q[15:8] == $past(ptr_q[15:8])) && (ptr_q[7:0] == $past(wr_data[7:0])));

  // R3: readback equals the stored pointer with the reserved bit cleared
  a_r3_readback: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ptr_rd_q == (ptr_q & READ_MASK)));

endmodule

// File: rtl/ptrwin_addr_gen.sv
module ptrwin_addr_gen
  import ptrwin_pkg::*;
#(
  parameter int OFS_W  = 11,
  parameter int BUF_W  = 4,
  parameter int LANE_W = 2
) (
  input  logic [PTR_W-1:0]     ptr_eff,
  input  logic [LANE_W-1:0]    lane,
  input  logic [BUF_W-1:0]     rx_head,
  input  logic [BUF_W-1:0]     pkt_num,
  output logic [BUF_W+OFS_W-1:0] addr
);

  logic [BUF_W-1:0] buf_idx;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    buf_idx = ptr_eff[RXSEL_BIT] ? rx_head : pkt_num;
    if (ptr_eff[AUTO_BIT])
      ofs = ptr_eff[OFS_W-1:0];
    else
      ofs = ptr_eff[OFS_W-1:0] + OFS_W'(lane);
    addr = {buf_idx, ofs};
  end

endmodule

// File: rtl/ptrwin_ram_port.sv
module ptrwin_ram_port #(
  parameter int AW     = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DATA_W-1:0] ram_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we <= acc_valid && acc_write;
      ram_re <= acc_valid && !acc_write;
      if (acc_valid) begin
        ram_addr  <= acc_addr;
        ram_wdata <= acc_wdata;
      end
    end
  end

  // R9: write and read requests never share a cycle
  a_r9_we_re_excl: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  // R9: a request follows each access and nothing else
  a_r9_req_follows: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !ram_we && !ram_re);

endmodule

// File: rtl/ptrwin_rd_ret.sv
module ptrwin_rd_ret #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic re_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      re_d1  <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      re_d1  <= ram_re;
      rvalid <= re_d1;
      if (re_d1) rdata <= ram_rdata;
    end
  end

  // R7: every RAM read is answered two cycles later
  a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
    ram_re |=> ##1 rvalid);

  // R7: no valid strobe without a RAM read
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !ram_re |=> ##1 !rvalid);

endmodule

// File: rtl/ptrwin_top.sv
module ptrwin_top
  import ptrwin_pkg::*;
#(
  parameter int OFS_W  = 11,
  parameter int BUF_W  = 4,
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             ptr_we,
  input  logic [15:0]            ptr_wdata,
  output logic [15:0]            ptr_rdata,
  input  logic                   dp_valid,
  input  logic                   dp_write,
  input  logic [LANE_W-1:0]      dp_lane,
  input  logic [DATA_W-1:0]      dp_wdata,
  output logic                   dp_rvalid,
  output logic [DATA_W-1:0]      dp_rdata,
  input  logic [BUF_W-1:0]       rx_head,
  input  logic [BUF_W-1:0]       pkt_num,
  output logic [BUF_W+OFS_W-1:0] ram_addr,
  output logic                   ram_we,
  output logic                   ram_re,
  output logic [DATA_W-1:0]      ram_wdata,
  input  logic [DATA_W-1:0]      ram_rdata
);

  localparam int AW = BUF_W + OFS_W;

  logic [PTR_W-1:0] ptr_eff;
  logic [PTR_W-1:0] ptr_q;
  logic [AW-1:0]    acc_addr;

  ptrwin_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .wr_be    (ptr_we),
    .wr_data  (ptr_wdata),
    .step     (dp_valid),
    .ptr_eff  (ptr_eff),
    .ptr_q    (ptr_q),
    .ptr_rd_q (ptr_rdata)
  );

  ptrwin_addr_gen #(.OFS_W(OFS_W), .BUF_W(BUF_W), .LANE_W(LANE_W)) u_addr (
    .ptr_eff (ptr_eff),
    .lane    (dp_lane),
    .rx_head (rx_head),
    .pkt_num (pkt_num),
    .addr    (acc_addr)
  );

  ptrwin_ram_port #(.AW(AW), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (dp_valid),
    .acc_write (dp_write),
    .acc_addr  (acc_addr),
    .acc_wdata (dp_wdata),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_wdata (ram_wdata)
  );

  ptrwin_rd_ret #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .ram_re    (ram_re),
    .ram_rdata (ram_rdata),
    .rvalid    (dp_rvalid),
    .rdata     (dp_rdata)
  );

  // R8: a same-cycle pointer write reaches the RAM address of that access
  a_r8_write_first: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && ptr_we == 2'b11) |=>
      ram_addr[OFS_W-1:0] == ($past(ptr_wdata[AUTO_BIT]) ?
        $past(ptr_wdata[OFS_W-1:0]) :
        $past(ptr_wdata[OFS_W-1:0]) + OFS_W'($past(dp_lane))));

endmodule

// File: tb/ptrwin_top_tb.sv
module ptrwin_top_tb;

  localparam int OFS_W  = 11;
  localparam int BUF_W  = 4;
  localparam int DATA_W = 8;
  localparam int AW     = BUF_W + OFS_W;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        ptr_we;
  logic [15:0]       ptr_wdata;
  logic [15:0]       ptr_rdata;
  logic              dp_valid, dp_write;
  logic [1:0]        dp_lane;
  logic [DATA_W-1:0] dp_wdata;
  logic              dp_rvalid;
  logic [DATA_W-1:0] dp_rdata;
  logic [BUF_W-1:0]  rx_head, pkt_num;
  logic [AW-1:0]     ram_addr;
  logic              ram_we, ram_re;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  always #10 clk = ~clk;

  ptrwin_top u_dut (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_rdata(ptr_rdata), .dp_valid(dp_valid), .dp_write(dp_write),
    .dp_lane(dp_lane), .dp_wdata(dp_wdata), .dp_rvalid(dp_rvalid),
    .dp_rdata(dp_rdata), .rx_head(rx_head), .pkt_num(pkt_num),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // buffer RAM model: synchronous, one-cycle read
  logic [DATA_W-1:0] ram_mem [int];
  always @(posedge clk) begin
    if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
    if (ram_re) ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : '0;
  end

  // reference model state
  logic [7:0] ref_mem [int];
  logic [15:0] ref_ptr;
  bit p0v, p1v, p2v;
  logic [7:0] p0d, p1d, p2d;
  bit exp_we, exp_re;
  int exp_addr;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] pwe, input logic [15:0] pwd,
                      input bit v, input bit w, input logic [1:0] ln,
                      input logic [7:0] wd, input string tag);
    logic [15:0] e;
    int b, o, a;
    bit nv;
    logic [7:0] nd;
    ptr_we = pwe; ptr_wdata = pwd; dp_valid = v; dp_write = w;
    dp_lane = ln; dp_wdata = wd;
    e = ref_ptr;
    if (pwe[0]) e[7:0]  = pwd[7:0];
    if (pwe[1]) e[15:8] = pwd[15:8];
    b = e[15] ? int'(rx_head) : int'(pkt_num);
    o = e[14] ? int'(e[10:0]) : ((int'(e[10:0]) + int'(ln)) % 2048);
    a = b * 2048 + o;
    exp_we = v && w;
    exp_re = v && !w;
    exp_addr = a;
    if (v && w) ref_mem[a] = wd;
    nv = v && !w;
    nd = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    if (v && e[14]) e[10:0] = e[10:0] + 11'd1;
    ref_ptr = e;
    @(posedge clk);
    p2v = p1v; p2d = p1d; p1v = p0v; p1d = p0d; p0v = nv; p0d = nd;
    @(negedge clk);
    chk(tag, "ptr_rdata", int'(ptr_rdata), int'(ref_ptr & 16'hF7FF));
    chk(tag, "dp_rvalid", int'(dp_rvalid), int'(p2v));
    if (p2v) chk(tag, "dp_rdata", int'(dp_rdata), int'(p2d));
    chk(tag, "ram_we", int'(ram_we), int'(exp_we));
    chk(tag, "ram_re", int'(ram_re), int'(exp_re));
    if (exp_we || exp_re) chk(tag, "ram_addr", int'(ram_addr), exp_addr);
    if (exp_we) chk(tag, "ram_wdata", int'(ram_wdata), int'(wd));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 16'h0, 0, 0, 2'd0, 8'h00, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ptr_we = '0; ptr_wdata = '0; dp_valid = 0; dp_write = 0;
    dp_lane = '0; dp_wdata = '0; rx_head = 4'd5; pkt_num = 4'd3;
    ref_ptr = '0; p0v = 0; p1v = 0; p2v = 0; p0d = 0; p1d = 0; p2d = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "ptr_rdata", int'(ptr_rdata), 0);
    chk("R1", "dp_rvalid", int'(dp_rvalid), 0);
    chk("R1", "ram_we", int'(ram_we), 0);
    chk("R1", "ram_re", int'(ram_re), 0);
    idle(2, "R1");

    // R2: byte-independent pointer writes
    step(2'b01, 16'hAA34, 0, 0, 2'd0, 8'h00, "R2");
    step(2'b10, 16'h1299, 0, 0, 2'd0, 8'h00, "R2");
    step(2'b01, 16'h0056, 0, 0, 2'd0, 8'h00, "R2");
    chk("R2", "ptr_after_lo", int'(ptr_rdata), 16'h1256);

    // R3: bit 11 masked on readback
    step(2'b11, 16'h0FFF, 0, 0, 2'd0, 8'h00, "R3");
    chk("R3", "ptr_masked", int'(ptr_rdata), 16'h07FF);
    step(2'b10, 16'h3800, 0, 0, 2'd0, 8'h00, "R3");
    chk("R3", "ptr_hi_masked", int'(ptr_rdata), 16'h30FF);

    // R5: lane offset with wrap, no increment
    step(2'b11, 16'h07FE, 0, 0, 2'd0, 8'h00, "R5");
    for (int i = 0; i < 4; i++) step(2'b00, 16'h0, 1, 1, 2'(i), 8'hA0 + 8'(i), "R5");
    for (int i = 3; i >= 0; i--) step(2'b00, 16'h0, 1, 0, 2'(i), 8'h00, "R5");
    idle(3, "R5");
    chk("R5", "ptr_unchanged", int'(ptr_rdata), 16'h07FE);

    // R4: buffer select by bit 15
    step(2'b11, 16'h8010, 1, 1, 2'd0, 8'h5A, "R4");
    step(2'b11, 16'h0010, 1, 0, 2'd0, 8'h00, "R4");
    pkt_num = 4'd5;
    step(2'b00, 16'h0, 1, 0, 2'd0, 8'h00, "R4");
    pkt_num = 4'd3; rx_head = 4'd9;
    step(2'b11, 16'h8010, 1, 0, 2'd0, 8'h00, "R4");
    idle(3, "R4");

    // R6: auto-increment, lane ignored, wrap at 2047
    step(2'b11, 16'h47FE, 0, 0, 2'd0, 8'h00, "R6");
    for (int i = 0; i < 4; i++) step(2'b00, 16'h0, 1, 1, 2'(3 - i), 8'hC0 + 8'(i), "R6");
    chk("R6", "ptr_wrapped", int'(ptr_rdata), 16'h4002);
    step(2'b11, 16'hC7FE, 0, 0, 2'd0, 8'h00, "R6");
    step(2'b11, 16'h47FE, 0, 0, 2'd0, 8'h00, "R6");
    for (int i = 0; i < 4; i++) step(2'b00, 16'h0, 1, 0, 2'(i), 8'h00, "R6");
    idle(3, "R6");

    // R7: read immediately after write, and back-to-back reads
    step(2'b11, 16'h0100, 1, 1, 2'd1, 8'h77, "R7");
    step(2'b00, 16'h0, 1, 0, 2'd1, 8'h00, "R7");
    step(2'b00, 16'h0, 1, 1, 2'd1, 8'h78, "R7");
    step(2'b00, 16'h0, 1, 0, 2'd1, 8'h00, "R7");
    idle(3, "R7");

    // R8: pointer write in the same cycle as a data access
    step(2'b11, 16'h4200, 1, 1, 2'd2, 8'h11, "R8");
    step(2'b11, 16'h4200, 1, 0, 2'd3, 8'h00, "R8");
    step(2'b01, 16'h0020, 1, 1, 2'd0, 8'h22, "R8");
    step(2'b10, 16'h0000, 1, 0, 2'd2, 8'h00, "R8");
    step(2'b01, 16'h0020, 1, 0, 2'd0, 8'h00, "R8");
    idle(3, "R8");

    // R9: mixed traffic on both buffers
    rx_head = 4'd15; pkt_num = 4'd0;
    for (int i = 0; i < 8; i++)
      step(2'b00, 16'h0, 1, (i % 3) != 0, 2'(i), 8'(i * 13), "R9");
    idle(3, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule